// File: doc/BRIEF.md
# Fused Multiply-Add Align and Sum Datapath

This block is the middle of a single-precision fused multiply-add unit. It takes the decoded operands: the effective sign of the product, the effective sign of the addend, three signed unbiased exponents and three 24-bit mantissas with the hidden bit already set. The block forms the exact product and lines it up against the addend. It then adds or subtracts the two and normalizes the result. The output is an unrounded 27-bit mantissa: 24 significant bits and three guard bits, where the lowest bit is sticky. It also gives the result sign and exponent, plus a flag for exact cancellation. An upstream stage resolves NaN, infinity and zero-product cases. A downstream stage rounds and packs.

Both operands are carried in a 64-bit working frame with the leading one at bit 62. Every right shift in the block is a jamming shift: any bit shifted out is ORed into bit 0. The block is a fixed two-stage pipeline. An operand set presented with `valid_i` appears on the outputs two clock edges later with `valid_o`.

Top module: `fma_align_add`

## Requirements
- R1: The product exponent is x_exp + y_exp. The product of the two 24-bit mantissas is placed so that its leading one lands at frame bit 62. When the product is 2.0 or more, the exponent is incremented by one.
- R2: When `z_zero_i` is 1, the output is the product alone, with the product sign and exponent. `add_sign_i`, `z_exp_i` and `z_man_i` have no effect.
- R3: The operand with the smaller exponent is shifted right by the exponent difference. The output exponent is the larger of the two.
- R4: An alignment distance of 63 or more leaves only the sticky bit (bit 0) of the shifted operand. That bit is 1 because the operand is nonzero.
- R5: With equal signs, the magnitudes are added. A carry into frame bit 63 shifts the sum right by one and increments the exponent. The sign is the common sign.
- R6: With differing signs, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R7: An exact zero difference sets `zero_o`=1, `man_o`=0 and `exp_o`=0. `sign_o` then equals `rnd_dn_i`, where 1 means round toward minus infinity.
- R8: After a subtraction, the result is shifted left until its leading one is at frame bit 62. The exponent is decremented by the shift count.
- R9: For every nonzero result, `man_o[26]` is 1. `man_o` is frame bits 62..36, with bit 0 ORed with all of frame bits 35..0.
- R10: A result appears with `valid_o`=1 exactly two rising clock edges after `valid_i`=1 is sampled. `valid_o` is 0 during reset and after reset until an accepted operand set has passed through both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand set valid |
| prod_sign_i | input | 1 | Effective sign of x*y |
| add_sign_i | input | 1 | Effective sign of z |
| rnd_dn_i | input | 1 | Rounding toward minus infinity selected |
| z_zero_i | input | 1 | Addend is zero |
| x_exp_i | input | EXP_W (10) | Signed unbiased exponent of x |
| y_exp_i | input | EXP_W (10) | Signed unbiased exponent of y |
| z_exp_i | input | EXP_W (10) | Signed unbiased exponent of z |
| x_man_i | input | MAN_W (24) | x mantissa, hidden bit set |
| y_man_i | input | MAN_W (24) | y mantissa, hidden bit set |
| z_man_i | input | MAN_W (24) | z mantissa, hidden bit set |
| valid_o | output | 1 | Result valid |
| sign_o | output | 1 | Result sign |
| zero_o | output | 1 | Exact cancellation |
| exp_o | output | EXP_W+2 (12) | Signed result exponent |
| man_o | output | OUT_W (27) | Unrounded mantissa, bit 0 sticky |

## Verification
The assertions hold on every cycle for these properties:
- the two-cycle valid latency;
- the leading one at bit 26 of any nonzero result;
- the clean encoding of a cancelled result and its rounding-dependent sign;
- cancellation arising only from an unlike-sign sum with a nonzero addend;
- the product sign on the addend-zero path.

The arithmetic values need the bench's scenarios: product overflow renormalization, alignment in both directions, saturation of a very long shift, jamming of lost bits into the sticky position, carry out of an addition, and the long left shift after deep cancellation.

// File: rtl/fma_pkg.sv
package fma_pkg;
  localparam int FRAME_W = 64;
  localparam int LEAD_BIT = FRAME_W - 2;
  localparam int SH_W = $clog2(FRAME_W) + 1;
  localparam int MAN_W = 24;
  localparam int OUT_W = 27;
  localparam int EXP_W = 10;

  // right shift, discarded bits jammed into bit 0; >= FRAME_W-1 keeps only sticky
  function automatic logic [FRAME_W-1:0] sticky_srl(input logic [FRAME_W-1:0] v,
                                                    input logic [SH_W-1:0] sh);
    logic [FRAME_W-1:0] r;
    logic [FRAME_W-1:0] mask;
    if (sh >= SH_W'(FRAME_W - 1)) begin
      r = '0;
      r[0] = |v;
    end else begin
      mask = (FRAME_W'(1) << sh) - FRAME_W'(1);
      r = v >> sh;
      r[0] = r[0] | (|(v & mask));
    end
    return r;
  endfunction

  // frame with leading one at LEAD_BIT -> OUT_W mantissa with sticky LSB
  function automatic logic [OUT_W-1:0] frame_to_man(input logic [FRAME_W-1:0] v);
    logic [FRAME_W-1:0] r;
    r = sticky_srl(v, SH_W'(LEAD_BIT - (OUT_W - 1)));
    return r[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/fma_lzc.sv
module fma_lzc #(
  parameter int W  = 63,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins: scan upward, last hit overrides
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fma_prod_align.sv
module fma_prod_align
  import fma_pkg::*;
#(
  parameter int MAN_BITS = fma_pkg::MAN_W,
  parameter int EXP_BITS = fma_pkg::EXP_W,
  localparam int EW = EXP_BITS + 2
) (
  input  logic signed [EXP_BITS-1:0] x_exp_i,
  input  logic signed [EXP_BITS-1:0] y_exp_i,
  input  logic signed [EXP_BITS-1:0] z_exp_i,
  input  logic [MAN_BITS-1:0]        x_man_i,
  input  logic [MAN_BITS-1:0]        y_man_i,
  input  logic [MAN_BITS-1:0]        z_man_i,
  input  logic                       z_zero_i,
  output logic signed [EW-1:0]       exp_o,
  output logic [FRAME_W-1:0]         pf_o,
  output logic [FRAME_W-1:0]         zf_o
);
  localparam int PW    = 2 * MAN_BITS;
  localparam int P_SHL = FRAME_W - PW;
  localparam int Z_SHL = LEAD_BIT - (MAN_BITS - 1);
  localparam int DW    = EW + 1;

  logic [PW-1:0]          prod;
  logic [FRAME_W-1:0]     pf0, pf1, zf0;
  logic signed [EW-1:0]   pe0, pe1;
  logic signed [DW-1:0]   ediff;
  logic [DW-1:0]          emag;
  logic [SH_W-1:0]        sat;

  always_comb begin
    prod = PW'(x_man_i) * PW'(y_man_i);
    pf0  = FRAME_W'(prod) << P_SHL;
    pe0  = EW'(x_exp_i) + EW'(y_exp_i);
    if (pf0[FRAME_W-1]) begin
      pf1 = sticky_srl(pf0, SH_W'(1));
      pe1 = pe0 + EW'(1);
    end else begin
      pf1 = pf0;
      pe1 = pe0;
    end
    zf0 = FRAME_W'(z_man_i) << Z_SHL;

    ediff = DW'(z_exp_i) - DW'(pe1);
    emag  = ediff[DW-1] ? DW'(-ediff) : DW'(ediff);
    sat   = (emag > DW'(FRAME_W - 1)) ? SH_W'(FRAME_W - 1) : SH_W'(emag);

    pf_o  = pf1;
    zf_o  = zf0;
    exp_o = pe1;
    if (!z_zero_i) begin
      if (!ediff[DW-1] && ediff != '0) begin
        pf_o  = sticky_srl(pf1, sat);
        exp_o = EW'(z_exp_i);
      end else if (ediff[DW-1]) begin
        zf_o  = sticky_srl(zf0, sat);
      end
    end
  end
endmodule

// File: rtl/fma_sum_norm.sv
module fma_sum_norm
  import fma_pkg::*;
#(
  parameter int EXP_BITS = fma_pkg::EXP_W,
  localparam int EW = EXP_BITS + 2
) (
  input  logic                 prod_sign_i,
  input  logic                 add_sign_i,
  input  logic                 rnd_dn_i,
  input  logic                 z_zero_i,
  input  logic signed [EW-1:0] exp_i,
  input  logic [FRAME_W-1:0]   pf_i,
  input  logic [FRAME_W-1:0]   zf_i,
  output logic                 sign_o,
  output logic                 zero_o,
  output logic signed [EW-1:0] exp_o,
  output logic [OUT_W-1:0]     man_o
);
  localparam int LZ_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sum, diff, mag;
  logic               z_ge;
  logic [LZ_W-1:0]    lz;

  always_comb begin
    sum  = pf_i + zf_i;
    z_ge = zf_i >= pf_i;
    diff = z_ge ? (zf_i - pf_i) : (pf_i - zf_i);
  end

  fma_lzc #(.W(FRAME_W - 1), .CW(LZ_W)) lzc_i (
    .vec_i (diff[FRAME_W-2:0]),
    .cnt_o (lz)
  );

  always_comb begin
    zero_o = 1'b0;
    sign_o = prod_sign_i;
    exp_o  = exp_i;
    mag    = pf_i;
    if (z_zero_i) begin
      mag = pf_i;
    end else if (prod_sign_i == add_sign_i) begin
      sign_o = add_sign_i;
      if (sum[FRAME_W-1]) begin
        mag   = sticky_srl(sum, SH_W'(1));
        exp_o = exp_i + EW'(1);
      end else begin
        mag = sum;
      end
    end else begin
      sign_o = z_ge ? add_sign_i : prod_sign_i;
      mag    = diff << lz;
      exp_o  = exp_i - EW'(lz);
      if (diff == '0) zero_o = 1'b1;
    end
    man_o = frame_to_man(mag);
    if (zero_o) begin
      sign_o = rnd_dn_i;
      exp_o  = '0;
      man_o  = '0;
    end
  end
endmodule

// File: rtl/fma_align_add.sv
module fma_align_add
  import fma_pkg::*;
#(
  parameter int MAN_BITS = fma_pkg::MAN_W,
  parameter int EXP_BITS = fma_pkg::EXP_W,
  localparam int EW = EXP_BITS + 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       prod_sign_i,
  input  logic                       add_sign_i,
  input  logic                       rnd_dn_i,
  input  logic                       z_zero_i,
  input  logic signed [EXP_BITS-1:0] x_exp_i,
  input  logic signed [EXP_BITS-1:0] y_exp_i,
  input  logic signed [EXP_BITS-1:0] z_exp_i,
  input  logic [MAN_BITS-1:0]        x_man_i,
  input  logic [MAN_BITS-1:0]        y_man_i,
  input  logic [MAN_BITS-1:0]        z_man_i,
  output logic                       valid_o,
  output logic                       sign_o,
  output logic                       zero_o,
  output logic signed [EW-1:0]       exp_o,
  output logic [OUT_W-1:0]           man_o
);
  logic signed [EW-1:0] a_exp;
  logic [FRAME_W-1:0]   a_pf, a_zf;

  logic                 s1_vld, s1_ps, s1_zs, s1_rd, s1_zz;
  logic signed [EW-1:0] s1_exp;
  logic [FRAME_W-1:0]   s1_pf, s1_zf;

  logic                 b_sign, b_zero;
  logic signed [EW-1:0] b_exp;
  logic [OUT_W-1:0]     b_man;

  fma_prod_align #(.MAN_BITS(MAN_BITS), .EXP_BITS(EXP_BITS)) align_i (
    .x_exp_i  (x_exp_i),
    .y_exp_i  (y_exp_i),
    .z_exp_i  (z_exp_i),
    .x_man_i  (x_man_i),
    .y_man_i  (y_man_i),
    .z_man_i  (z_man_i),
    .z_zero_i (z_zero_i),
    .exp_o    (a_exp),
    .pf_o     (a_pf),
    .zf_o     (a_zf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_ps  <= 1'b0;
      s1_zs  <= 1'b0;
      s1_rd  <= 1'b0;
      s1_zz  <= 1'b0;
      s1_exp <= '0;
      s1_pf  <= '0;
      s1_zf  <= '0;
    end else begin
      s1_vld <= valid_i;
      if (valid_i) begin
        s1_ps  <= prod_sign_i;
        s1_zs  <= add_sign_i;
        s1_rd  <= rnd_dn_i;
        s1_zz  <= z_zero_i;
        s1_exp <= a_exp;
        s1_pf  <= a_pf;
        s1_zf  <= a_zf;
      end
    end
  end

  fma_sum_norm #(.EXP_BITS(EXP_BITS)) sum_i (
    .prod_sign_i (s1_ps),
    .add_sign_i  (s1_zs),
    .rnd_dn_i    (s1_rd),
    .z_zero_i    (s1_zz),
    .exp_i       (s1_exp),
    .pf_i        (s1_pf),
    .zf_i        (s1_zf),
    .sign_o      (b_sign),
    .zero_o      (b_zero),
    .exp_o       (b_exp),
    .man_o       (b_man)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      zero_o  <= 1'b0;
      exp_o   <= '0;
      man_o   <= '0;
    end else begin
      valid_o <= s1_vld;
      if (s1_vld) begin
        sign_o <= b_sign;
        zero_o <= b_zero;
        exp_o  <= b_exp;
        man_o  <= b_man;
      end
    end
  end
endmodule

// File: rtl/fma_align_add_chk.sv
module fma_align_add_chk #(
  parameter int EW    = 12,
  parameter int OUT_W = 27
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          prod_sign_i,
  input logic          add_sign_i,
  input logic          rnd_dn_i,
  input logic          z_zero_i,
  input logic          valid_o,
  input logic          sign_o,
  input logic          zero_o,
  input logic [EW-1:0] exp_o,
  input logic [OUT_W-1:0] man_o
);
  p_lat_fwd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  p_lat_back_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));
  p_lead_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !zero_o) |-> man_o[OUT_W-1]);
  p_zero_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zero_o) |-> (man_o == '0 && exp_o == '0));
  p_zero_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zero_o) |-> (sign_o == $past(rnd_dn_i, 2)));
  p_zero_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zero_o) |-> ($past(prod_sign_i, 2) != $past(add_sign_i, 2) && !$past(z_zero_i, 2)));
  p_zz_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(z_zero_i, 2)) |-> (sign_o == $past(prod_sign_i, 2) && !zero_o));
endmodule

bind fma_align_add fma_align_add_chk #(.EW(EW), .OUT_W(fma_pkg::OUT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .prod_sign_i (prod_sign_i),
  .add_sign_i  (add_sign_i),
  .rnd_dn_i    (rnd_dn_i),
  .z_zero_i    (z_zero_i),
  .valid_o     (valid_o),
  .sign_o      (sign_o),
  .zero_o      (zero_o),
  .exp_o       (exp_o),
  .man_o       (man_o)
);

// File: tb/fma_align_add_tb_top.sv
`timescale 1ns/1ps
module fma_align_add_tb_top;
  typedef struct packed {
    logic        ps, zs, rd, zz;
    logic [9:0]  xe, ye, ze;
    logic [23:0] xm, ym, zm;
    logic        e_sign, e_zero;
    logic [11:0] e_exp;
    logic [26:0] e_man;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R1: 1.0*1.0, z zero
    '{1'b0,1'b0,1'b0,1'b1, 10'd0,10'd0,10'd0, 24'h800000,24'h800000,24'h000000, 1'b0,1'b0,12'd0,27'h4000000, 4'd1},
    // R2: 1.5*1.5 overflow renormalized, negative product sign
    '{1'b1,1'b0,1'b0,1'b1, 10'd0,10'd0,10'd0, 24'hC00000,24'hC00000,24'h000000, 1'b1,1'b0,12'd1,27'h4800000, 4'd2},
    // R5: 1+1 carry out
    '{1'b0,1'b0,1'b0,1'b0, 10'd0,10'd0,10'd0, 24'h800000,24'h800000,24'h800000, 1'b0,1'b0,12'd1,27'h4000000, 4'd5},
    // R7: exact cancel, round to nearest
    '{1'b0,1'b1,1'b0,1'b0, 10'd0,10'd0,10'd0, 24'h800000,24'h800000,24'h800000, 1'b0,1'b1,12'd0,27'h0, 4'd7},
    // R7: exact cancel, round down gives negative zero
    '{1'b0,1'b1,1'b1,1'b0, 10'd0,10'd0,10'd0, 24'h800000,24'h800000,24'h800000, 1'b1,1'b1,12'd0,27'h0, 4'd7},
    // R6: addend larger, takes addend sign
    '{1'b0,1'b1,1'b0,1'b0, 10'd0,10'd0,10'd0, 24'h800000,24'h800000,24'hC00000, 1'b1,1'b0,12'hFFF,27'h4000000, 4'd6},
    // R6: product larger, takes product sign
    '{1'b0,1'b1,1'b0,1'b0, 10'd0,10'd0,10'd0, 24'hC00000,24'h800000,24'h800000, 1'b0,1'b0,12'hFFF,27'h4000000, 4'd6},
    // R3: addend exponent smaller by 3
    '{1'b0,1'b0,1'b0,1'b0, 10'd3,10'd2,10'd2, 24'h800000,24'h800000,24'h800000, 1'b0,1'b0,12'd5,27'h4800000, 4'd3},
    // R9: bits below the output jam into sticky
    '{1'b0,1'b0,1'b0,1'b0, 10'd0,10'd0,10'h3E2, 24'h800000,24'h800000,24'h800001, 1'b0,1'b0,12'd0,27'h4000001, 4'd9},
    // R4: alignment distance 200 saturates to sticky
    '{1'b0,1'b0,1'b0,1'b0, 10'd0,10'd0,10'h338, 24'h800000,24'h800000,24'h800000, 1'b0,1'b0,12'd0,27'h4000001, 4'd4},
    // R3: product exponent smaller, product shifted
    '{1'b0,1'b0,1'b0,1'b0, 10'd0,10'd0,10'd4, 24'h800000,24'h800000,24'h800000, 1'b0,1'b0,12'd4,27'h4400000, 4'd3},
    // R8: deep cancellation, left shift by 23
    '{1'b0,1'b1,1'b0,1'b0, 10'd0,10'd0,10'd0, 24'h800001,24'h800000,24'h800000, 1'b0,1'b0,12'hFE9,27'h4000000, 4'd8},
    // R2: z zero with junk addend fields, negative exponents
    '{1'b0,1'b1,1'b0,1'b1, 10'h3FB,10'h3F9,10'd100, 24'h800001,24'h800000,24'h123456, 1'b0,1'b0,12'hFF4,27'h4000008, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, ps = 1'b0, zs = 1'b0, rd = 1'b0, zz = 1'b0;
  logic signed [9:0] xe = '0, ye = '0, ze = '0;
  logic [23:0] xm = '0, ym = '0, zm = '0;
  logic valid_o, sign_o, zero_o;
  logic signed [11:0] exp_o;
  logic [26:0] man_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fma_align_add dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .prod_sign_i(ps), .add_sign_i(zs), .rnd_dn_i(rd), .z_zero_i(zz),
    .x_exp_i(xe), .y_exp_i(ye), .z_exp_i(ze),
    .x_man_i(xm), .y_man_i(ym), .z_man_i(zm),
    .valid_o(valid_o), .sign_o(sign_o), .zero_o(zero_o),
    .exp_o(exp_o), .man_o(man_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ps = v.ps; zs = v.zs; rd = v.rd; zz = v.zz;
    xe = v.xe; ye = v.ye; ze = v.ze;
    xm = v.xm; ym = v.ym; zm = v.zm;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    string r;
    r = $sformatf("R%0d(v%0d)", v.req, idx);
    chk(valid_o == 1'b1, r, "valid", 32'(valid_o), 32'd1);
    chk(sign_o == v.e_sign, r, "sign", 32'(sign_o), 32'(v.e_sign));
    chk(zero_o == v.e_zero, r, "zero", 32'(zero_o), 32'(v.e_zero));
    chk(exp_o == v.e_exp, r, "exp", 32'(exp_o), 32'(v.e_exp));
    chk(man_o == v.e_man, r, "man", 32'(man_o), 32'(v.e_man));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R10", "valid in reset", 32'(valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R10", "valid after reset", 32'(valid_o), 32'd0);

    // table walk: drive at negedge, sample two edges later
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      chk(valid_o == 1'b0, "R10", "valid after one edge", 32'(valid_o), 32'd0);
      @(negedge clk);
      check_vec(VECS[i], i);
      @(negedge clk);
      chk(valid_o == 1'b0, "R10", "valid drop", 32'(valid_o), 32'd0);
    end

    // R10: back-to-back issue, results on consecutive cycles
    drive(VECS[7]); valid_i = 1'b1;
    @(negedge clk);
    drive(VECS[11]);
    @(negedge clk);
    valid_i = 1'b0;
    check_vec(VECS[7], 7);
    @(negedge clk);
    check_vec(VECS[11], 11);

    // R2: addend fields changed under z zero leave output unchanged
    drive(VECS[0]); zs = 1'b1; ze = 10'sd50; zm = 24'hFFFFFF; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    check_vec(VECS[0], 0);

    // R10: reset while a result is in flight discards it
    drive(VECS[2]); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(valid_o == 1'b0, "R10", "valid flushed", 32'(valid_o), 32'd0);
    @(negedge clk);
    chk(valid_o == 1'b0, "R10", "valid flushed late", 32'(valid_o), 32'd0);

    finish_run();
  end
endmodule